// File: doc/BRIEF.md
# Network Controller Power-State Wake Manager

This block holds the device power state of a network controller and turns it into gating signals for the receive path, the transmit path and the bus-master datapath. A 2-bit state is written by software. State 0 is full power. Codes 1, 2 and 3 are the three low-power levels, and all three behave the same way inside this block. In any low-power level the receive state machine is halted. Receive interrupt-status updates are suppressed. The receive FIFO is told to keep its contents and its status. Transmission and bus mastering stop, and the transmit FIFO is told to keep its contents.

While the device is in low power, the block watches three wake strobes: magic packet on bit 0, wakeup frame on bit 1 and link re-established on bit 2. Each strobe has its own enable. An enabled strobe latches a per-source status bit. That status drives an active-low, level PME output until software clears it. The status survives the return to full power.

When the device returns to full power, the block issues a one-cycle retransmit request, but only if a transmit frame was in progress when the device entered low power. The receive side changes state only at a frame boundary. A build parameter selects between two behaviours for a receive frame that is in progress when the power-down write arrives: wait for it to finish, or abort it at once. The block has no data stream, so every pin is a plain control or status level or a strobe, and none of them uses a valid/ready handshake.

Top module: `pwr_wake_mgr`

## Requirements
- R1: After reset the state is 0 (full power). `rx_run`, `rx_stat_en`, `tx_run` and `bm_run` are 1. `rx_keep`, `tx_hold`, `tx_replay` and `rx_abort` are 0. `pme_n` is 1 and `wake_src` is all zeros.
- R2: A strobe on `ps_wr` loads `ps_wdata` into `ps_cur` at the next clock edge. The codes are 00 = D0, 01 = D1, 10 = D2 and 11 = D3. From that edge on, any nonzero code drives `tx_run` and `bm_run` to 0 and `tx_hold` to 1. Code 00 restores `tx_run` and `bm_run` to 1 and `tx_hold` to 0.
- R3: When the receive side is down, `rx_run` and `rx_stat_en` are 0 and `rx_keep` is 1. The receive side is down only while the state is nonzero. A write of 00 brings it back up at the next edge.
- R4: In the default drain build (`RX_DRAIN`=1), a power-down write that arrives while `rx_frame_busy`=1 keeps the receive side up. The receive side goes down at the first edge at which `rx_frame_busy` is 0. In the drop build (`RX_DRAIN`=0), the receive side goes down at the edge of the write. If a frame was busy at that edge, `rx_abort` pulses for one cycle.
- R5: In a nonzero state, a strobe on `wake_evt[i]` with `wake_en[i]`=1 sets `wake_src[i]` at the next edge. A strobe on a source with `wake_en[i]`=0 leaves `wake_src` unchanged.
- R6: While `ps_cur` is 00, wake strobes have no effect on `wake_src` or `pme_n`. This includes a strobe in the same cycle as a power-down write.
- R7: `pme_n` is 0 exactly when `pme_en`=1 and any `wake_src` bit is set. `wake_src` holds across idle cycles and across a return to state 00. A `pme_clr` strobe clears it at the next edge.
- R8: A write of 00 from a nonzero state pulses `tx_replay` for one cycle, starting at that edge. The pulse occurs only if `tx_frame_busy` was 1 at the write that left state 00.
- R9: A write from one nonzero state to another keeps all gating in place. It does not re-capture the transmit-busy flag and does not pulse `tx_replay`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ps_wr | input | 1 | Power-state write strobe |
| ps_wdata | input | 2 | Power-state code to write |
| rx_frame_busy | input | 1 | Receive frame in progress |
| tx_frame_busy | input | 1 | Transmit frame in progress |
| wake_evt | input | N_WAKE | Wake strobes: bit 0 magic packet, bit 1 wakeup frame, bit 2 link re-established |
| wake_en | input | N_WAKE | Per-source wake enable |
| pme_en | input | 1 | PME output enable |
| pme_clr | input | 1 | Strobe that clears the wake status |
| ps_cur | output | 2 | Current power state |
| rx_run | output | 1 | Receive state machine enable |
| rx_stat_en | output | 1 | Receive interrupt-status update enable |
| rx_keep | output | 1 | Receive FIFO retain (no flush) |
| rx_abort | output | 1 | One-cycle drop of the in-progress receive frame (drop build only) |
| tx_run | output | 1 | Transmit enable |
| tx_hold | output | 1 | Transmit FIFO retain |
| bm_run | output | 1 | Bus-master enable |
| tx_replay | output | 1 | One-cycle retransmit request |
| pme_n | output | 1 | Active-low PME |
| wake_src | output | N_WAKE | Latched wake status per source |

## Verification
The bench builds two instances with `N_WAKE`=3. The first uses the drain build (`RX_DRAIN`=1), and the bench compares its full output vector through a scoreboard. The second uses the drop build (`RX_DRAIN`=0) and receives the same stimulus. That second instance makes the immediate shutdown and the abort pulse observable, and both builds see the same power-down write while a receive frame is in progress. With three sources, the bench can apply a strobe on a disabled source and one on an enabled source, and it can show that a set status bit survives the return to state 00.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;
  localparam int PS_W = 2;
  typedef enum logic [PS_W-1:0] {
    PS_D0 = 2'b00,
    PS_D1 = 2'b01,
    PS_D2 = 2'b10,
    PS_D3 = 2'b11
  } pstate_e;
endpackage

// File: rtl/pwr_state_reg.sv
module pwr_state_reg
  import pwr_wake_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ps_wr,
  input  logic [PS_W-1:0] ps_wdata,
  output logic [PS_W-1:0] ps_q,
  output logic            cur_low,
  output logic            next_low,
  output logic            wr_low
);
  logic [PS_W-1:0] ps_d;

  always_comb begin
    ps_d = ps_wr ? ps_wdata : ps_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ps_q <= PS_D0;
    else        ps_q <= ps_d;
  end

  assign cur_low  = (ps_q != PS_D0);
  assign next_low = (ps_d != PS_D0);
  assign wr_low   = (ps_wdata != PS_D0);

  // R2: a write lands one edge later
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ps_wr |=> (ps_q == $past(ps_wdata)));
endmodule

// File: rtl/pwr_rx_gate.sv
module pwr_rx_gate #(
  parameter bit RX_DRAIN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic next_low,
  input  logic rx_frame_busy,
  output logic rx_down,
  output logic rx_abort
);
  generate
    if (RX_DRAIN) begin : g_drain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_down <= 1'b0;
        else        rx_down <= next_low && (rx_down || !rx_frame_busy);
      end
      assign rx_abort = 1'b0;

      // R4: receive side only stops between frames
      a_r4_frame_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_down) |-> !$past(rx_frame_busy));
    end else begin : g_drop
      logic abort_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rx_down <= 1'b0;
          abort_q <= 1'b0;
        end else begin
          rx_down <= next_low;
          abort_q <= next_low && !rx_down && rx_frame_busy;
        end
      end
      assign rx_abort = abort_q;

      // R4: abort is a single pulse
      a_r4_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_abort |=> !rx_abort);
    end
  endgenerate
endmodule

// File: rtl/pwr_tx_resume.sv
module pwr_tx_resume (
  input  logic clk,
  input  logic rst_n,
  input  logic ps_wr,
  input  logic wr_low,
  input  logic cur_low,
  input  logic tx_frame_busy,
  output logic tx_replay
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      tx_replay <= 1'b0;
    end else begin
      tx_replay <= 1'b0;
      if (ps_wr && !cur_low && wr_low) begin
        pend_q <= tx_frame_busy;
      end else if (ps_wr && cur_low && !wr_low) begin
        tx_replay <= pend_q;
        pend_q    <= 1'b0;
      end
    end
  end

  // R8: single-cycle request
  a_r8_replay_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_replay |=> !tx_replay);
  // R8 / R9: request only on a return to D0
  a_r8_replay_on_d0: assert property (@(posedge clk) disable iff (!rst_n)
    tx_replay |-> $past(ps_wr && cur_low && !wr_low));
endmodule

// File: rtl/pwr_wake_pme.sv
module pwr_wake_pme #(
  parameter int N_WAKE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cur_low,
  input  logic [N_WAKE-1:0] wake_evt,
  input  logic [N_WAKE-1:0] wake_en,
  input  logic              pme_en,
  input  logic              pme_clr,
  output logic [N_WAKE-1:0] wake_src,
  output logic              pme_n
);
  logic [N_WAKE-1:0] hit;

  always_comb begin
    hit = wake_evt & wake_en & {N_WAKE{cur_low}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wake_src <= '0;
    else if (pme_clr) wake_src <= hit;
    else              wake_src <= wake_src | hit;
  end

  assign pme_n = !(pme_en && (|wake_src));

  // R7: status is sticky until cleared
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !pme_clr |=> ((wake_src & $past(wake_src)) == $past(wake_src)));
  // R6: full power ignores wake strobes
  a_r6_d0_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur_low && !pme_clr) |=> (wake_src == $past(wake_src)));
endmodule

// File: rtl/pwr_wake_mgr.sv
module pwr_wake_mgr
  import pwr_wake_pkg::*;
#(
  parameter int N_WAKE   = 3,
  parameter bit RX_DRAIN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ps_wr,
  input  logic [1:0]        ps_wdata,
  input  logic              rx_frame_busy,
  input  logic              tx_frame_busy,
  input  logic [N_WAKE-1:0] wake_evt,
  input  logic [N_WAKE-1:0] wake_en,
  input  logic              pme_en,
  input  logic              pme_clr,
  output logic [1:0]        ps_cur,
  output logic              rx_run,
  output logic              rx_stat_en,
  output logic              rx_keep,
  output logic              rx_abort,
  output logic              tx_run,
  output logic              tx_hold,
  output logic              bm_run,
  output logic              tx_replay,
  output logic              pme_n,
  output logic [N_WAKE-1:0] wake_src
);
  logic cur_low, next_low, wr_low, rx_down;

  pwr_state_reg u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .ps_wr    (ps_wr),
    .ps_wdata (ps_wdata),
    .ps_q     (ps_cur),
    .cur_low  (cur_low),
    .next_low (next_low),
    .wr_low   (wr_low)
  );

  pwr_rx_gate #(.RX_DRAIN(RX_DRAIN)) u_rx (
    .clk           (clk),
    .rst_n         (rst_n),
    .next_low      (next_low),
    .rx_frame_busy (rx_frame_busy),
    .rx_down       (rx_down),
    .rx_abort      (rx_abort)
  );

  pwr_tx_resume u_tx (
    .clk           (clk),
    .rst_n         (rst_n),
    .ps_wr         (ps_wr),
    .wr_low        (wr_low),
    .cur_low       (cur_low),
    .tx_frame_busy (tx_frame_busy),
    .tx_replay     (tx_replay)
  );

  pwr_wake_pme #(.N_WAKE(N_WAKE)) u_wake (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur_low  (cur_low),
    .wake_evt (wake_evt),
    .wake_en  (wake_en),
    .pme_en   (pme_en),
    .pme_clr  (pme_clr),
    .wake_src (wake_src),
    .pme_n    (pme_n)
  );

  assign rx_run     = !rx_down;
  assign rx_stat_en = !rx_down;
  assign rx_keep    = rx_down;
  assign tx_run     = !cur_low;
  assign bm_run     = !cur_low;
  assign tx_hold    = cur_low;

  // R3: receive side is down only in a low-power state
  a_r3_rx_down_only_low: assert property (@(posedge clk) disable iff (!rst_n)
    rx_keep |-> (ps_cur != PS_D0));
  // R8: replay request lands in full power
  a_r8_replay_in_d0: assert property (@(posedge clk) disable iff (!rst_n)
    tx_replay |-> (ps_cur == PS_D0) && tx_run);
endmodule

// File: tb/pwr_wake_mgr_tb.sv
module pwr_wake_mgr_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ps_wr = 1'b0;
  logic [1:0] ps_wdata = 2'b00;
  logic rx_frame_busy = 1'b0, tx_frame_busy = 1'b0;
  logic [2:0] wake_evt = 3'b000, wake_en = 3'b111;
  logic pme_en = 1'b1, pme_clr = 1'b0;

  logic [1:0] ps_cur, ps_cur_d;
  logic rx_run, rx_stat_en, rx_keep, rx_abort, tx_run, tx_hold, bm_run, tx_replay, pme_n;
  logic [2:0] wake_src, wake_src_d;
  logic rx_run_d, rx_stat_en_d, rx_keep_d, rx_abort_d, tx_run_d, tx_hold_d, bm_run_d;
  logic tx_replay_d, pme_n_d;

  int vectors = 0, fails = 0;
  bit done = 1'b0;
  logic [12:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  pwr_wake_mgr #(.N_WAKE(3), .RX_DRAIN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .ps_wr(ps_wr), .ps_wdata(ps_wdata),
    .rx_frame_busy(rx_frame_busy), .tx_frame_busy(tx_frame_busy),
    .wake_evt(wake_evt), .wake_en(wake_en), .pme_en(pme_en), .pme_clr(pme_clr),
    .ps_cur(ps_cur), .rx_run(rx_run), .rx_stat_en(rx_stat_en), .rx_keep(rx_keep),
    .rx_abort(rx_abort), .tx_run(tx_run), .tx_hold(tx_hold), .bm_run(bm_run),
    .tx_replay(tx_replay), .pme_n(pme_n), .wake_src(wake_src)
  );

  pwr_wake_mgr #(.N_WAKE(3), .RX_DRAIN(1'b0)) u_dut_drop (
    .clk(clk), .rst_n(rst_n), .ps_wr(ps_wr), .ps_wdata(ps_wdata),
    .rx_frame_busy(rx_frame_busy), .tx_frame_busy(tx_frame_busy),
    .wake_evt(wake_evt), .wake_en(wake_en), .pme_en(pme_en), .pme_clr(pme_clr),
    .ps_cur(ps_cur_d), .rx_run(rx_run_d), .rx_stat_en(rx_stat_en_d), .rx_keep(rx_keep_d),
    .rx_abort(rx_abort_d), .tx_run(tx_run_d), .tx_hold(tx_hold_d), .bm_run(bm_run_d),
    .tx_replay(tx_replay_d), .pme_n(pme_n_d), .wake_src(wake_src_d)
  );

  // expected vector from requirement terms
  function automatic logic [12:0] ev(input logic [1:0] ps, input logic rxdown,
                                     input logic rep, input logic pmen, input logic [2:0] src);
    logic low;
    low = (ps != 2'b00);
    return {ps, !rxdown, !rxdown, rxdown, !low, low, !low, rep, pmen, src};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // monitor: pops one expectation per edge it was queued for
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [12:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {ps_cur, rx_run, rx_stat_en, rx_keep, tx_run, tx_hold, bm_run, tx_replay, pme_n, wake_src};
      chk(a == e, t, {3'b0, a}, {3'b0, e});
    end
  end

  // driver: queue expectation for the coming edge, then release strobes
  task automatic go(input logic [12:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    ps_wr = 1'b0;
    wake_evt = 3'b000;
    pme_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    go(ev(2'b00, 0, 0, 1, 3'b000), "R1 reset state");
    chk(rx_abort_d == 1'b0, "R1 abort idle", {15'b0, rx_abort_d}, 16'd0);
    // R6: wake in D0 ignored
    wake_evt = 3'b111;
    go(ev(2'b00, 0, 0, 1, 3'b000), "R6 wake in D0");
    // R2/R3: enter D1 with tx frame busy; R6 strobe in write cycle ignored
    tx_frame_busy = 1'b1; ps_wr = 1'b1; ps_wdata = 2'b01; wake_evt = 3'b111;
    go(ev(2'b01, 1, 0, 1, 3'b000), "R2 R3 R6 enter D1");
    tx_frame_busy = 1'b0;
    // R9: D1 -> D3
    ps_wr = 1'b1; ps_wdata = 2'b11;
    go(ev(2'b11, 1, 0, 1, 3'b000), "R9 low to low");
    // R5: disabled source
    wake_en = 3'b110; wake_evt = 3'b001;
    go(ev(2'b11, 1, 0, 1, 3'b000), "R5 disabled source");
    // R5: enabled relink
    wake_evt = 3'b100;
    go(ev(2'b11, 1, 0, 0, 3'b100), "R5 relink wake");
    go(ev(2'b11, 1, 0, 0, 3'b100), "R7 hold 1");
    go(ev(2'b11, 1, 0, 0, 3'b100), "R7 hold 2");
    pme_en = 1'b0;
    go(ev(2'b11, 1, 0, 1, 3'b100), "R7 pme masked");
    pme_en = 1'b1;
    go(ev(2'b11, 1, 0, 0, 3'b100), "R7 pme unmasked");
    // R8: return to D0 with replay
    ps_wr = 1'b1; ps_wdata = 2'b00;
    go(ev(2'b00, 0, 1, 0, 3'b100), "R8 replay pulse");
    go(ev(2'b00, 0, 0, 0, 3'b100), "R8 pulse ends");
    // R6: enabled source in D0
    wake_evt = 3'b010;
    go(ev(2'b00, 0, 0, 0, 3'b100), "R6 enabled src in D0");
    // R7: clear
    pme_clr = 1'b1;
    go(ev(2'b00, 0, 0, 1, 3'b000), "R7 clear");
    // R4: power-down during receive frame
    rx_frame_busy = 1'b1; ps_wr = 1'b1; ps_wdata = 2'b10;
    go(ev(2'b10, 0, 0, 1, 3'b000), "R4 drain waits");
    chk(rx_run_d == 1'b0, "R4 drop stops", {15'b0, rx_run_d}, 16'd0);
    chk(rx_abort_d == 1'b1, "R4 drop abort", {15'b0, rx_abort_d}, 16'd1);
    go(ev(2'b10, 0, 0, 1, 3'b000), "R4 drain still waits");
    chk(rx_abort_d == 1'b0, "R4 abort single", {15'b0, rx_abort_d}, 16'd0);
    rx_frame_busy = 1'b0;
    go(ev(2'b10, 1, 0, 1, 3'b000), "R4 drain stops at boundary");
    // R8: no replay when tx idle at entry; R3 rx restored
    ps_wr = 1'b1; ps_wdata = 2'b00;
    go(ev(2'b00, 0, 0, 1, 3'b000), "R8 R3 no replay");
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule